// File: doc/BRIEF.md
# Saturating Signed Multiply-Accumulate Unit

This block keeps a signed 64-bit running total in two 32-bit halves and adds signed products into it. It has two operation kinds. The long kind multiplies two full 32-bit signed operands. The word kind multiplies only the signed low halves of the operands. A saturation-mode bit travels with each command. When it is clear, the sum wraps at 64 bits. When it is set, the clamp that applies depends on the operation kind.

A command enters on a valid/ready handshake. It passes through a product pipeline of `MUL_STAGES` registers. The total then changes, and a one-cycle completion pulse is raised. Only one command is in flight at a time. Software can load either half of the total directly while the unit is idle, and can read both halves at any time. A clear input empties the total and drops any command still in flight.

Top module: `mac_sat_unit`

## Requirements
- R1: After a synchronous reset, both halves of the total are zero, `done` is low and `cmd_ready` is high.
- R2: With `cmd_op`=0 (long), the full signed product of `opa` and `opb` is added to the 64-bit total `{acc_hi,acc_lo}`. With `cmd_sat`=0 the sum wraps modulo 2^64.
- R3: With `cmd_op`=1 (word), bits 15:0 of each operand are read as signed 16-bit values, and bits 31:16 have no effect. The sign-extended product is added to the total. With `cmd_sat`=0 the sum wraps modulo 2^64.
- R4: A command accepted at clock edge k updates the total at edge k+`MUL_STAGES`. `done` is high for exactly the one cycle that follows that edge.
- R5: `cmd_ready` is low from the edge that accepts a command until the edge that updates the total. A command held valid during that time is taken only once `cmd_ready` rises again.
- R6: For a long command with saturation on, a negative 64-bit sum has its high half ORed with 0xFFFF0000. A non-negative sum has its high half ANDed with 0x00007FFF. The low half is kept in both cases.
- R7: For a word command with saturation on, a sum above 2^31-1 leaves high=1, low=0x7FFFFFFF. A sum below -2^31 leaves high=1, low=0x80000000.
- R8: For a word command with saturation on, a sum inside the signed 32-bit range is written back unchanged.
- R9: While idle, `wr_hi_en` / `wr_lo_en` load the matching half of the total at the next edge. Each half can be loaded on its own.
- R10: Direct loads made while a command is in flight have no effect on the total.
- R11: `acc_clr` zeroes the total at the next edge. It forces `cmd_ready` low in its own cycle, so a command in that cycle is not taken. It also drops a command in flight, which then raises no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 1 | 0 = long 32x32, 1 = word 16x16 |
| cmd_sat | input | 1 | Saturation mode for this command |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| acc_clr | input | 1 | Zero the total, drop the command in flight |
| wr_hi_en | input | 1 | Load high half |
| wr_hi_data | input | 32 | Value for high half |
| wr_lo_en | input | 1 | Load low half |
| wr_lo_data | input | 32 | Value for low half |
| acc_hi | output | 32 | High half of the total |
| acc_lo | output | 32 | Low half of the total |
| done | output | 1 | One-cycle pulse after the total has been updated |

## Verification
The saturation boundaries are the hardest points to reach from the ports. Small operands can only push the total past the signed 32-bit limits, or past the 64-bit wrap point, after thousands of steps. The stimulus therefore uses the direct-load path to place the total just inside each limit. A single small product then carries it across, toward both the upper and the lower limit. A clear that arrives while a product is still in the pipeline is timed so that it lands between acceptance and completion. A command held valid across the busy window shows when it is taken again.

// File: rtl/mac_sat_unit.sv
`timescale 1ns/1ps
module mac_sat_unit #(
  parameter int MUL_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic        cmd_op,
  input  logic        cmd_sat,
  input  logic [31:0] opa,
  input  logic [31:0] opb,
  input  logic        acc_clr,
  input  logic        wr_hi_en,
  input  logic [31:0] wr_hi_data,
  input  logic        wr_lo_en,
  input  logic [31:0] wr_lo_data,
  output logic [31:0] acc_hi,
  output logic [31:0] acc_lo,
  output logic        done
);
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;
  localparam int ACC_W  = 2 * WORD_W;
  localparam int STG    = (MUL_STAGES < 1) ? 1 : MUL_STAGES;

  localparam logic signed [ACC_W-1:0] WORD_MIN = -(ACC_W'(1) << (WORD_W - 1));
  localparam logic signed [ACC_W-1:0] WORD_MAX = (ACC_W'(1) << (WORD_W - 1)) - 1;
  localparam logic [WORD_W-1:0] HI_NEG_SET  = {{HALF_W{1'b1}}, {HALF_W{1'b0}}};
  localparam logic [WORD_W-1:0] HI_POS_KEEP = WORD_W'((1 << (HALF_W - 1)) - 1);
  localparam logic [WORD_W-1:0] SAT_MARK    = WORD_W'(1);
  localparam logic [WORD_W-1:0] LO_MAX      = WORD_MAX[WORD_W-1:0];
  localparam logic [WORD_W-1:0] LO_MIN      = WORD_MIN[WORD_W-1:0];

  logic [STG-1:0] pv, pop, psat;
  logic signed [ACC_W-1:0] pprod [STG];

  logic busy, fin, accept;
  assign busy      = |pv;
  assign fin       = pv[STG-1];
  assign cmd_ready = !busy && !acc_clr;
  assign accept    = cmd_valid && cmd_ready;

  logic signed [ACC_W-1:0]  prod_long, prod_word, prod_in;
  logic signed [WORD_W-1:0] prod_half;
  assign prod_long = $signed({{WORD_W{opa[WORD_W-1]}}, opa}) *
                     $signed({{WORD_W{opb[WORD_W-1]}}, opb});
  assign prod_half = $signed(opa[HALF_W-1:0]) * $signed(opb[HALF_W-1:0]);
  assign prod_word = {{WORD_W{prod_half[WORD_W-1]}}, prod_half};
  assign prod_in   = cmd_op ? prod_word : prod_long;

  always_ff @(posedge clk) begin
    if (rst || acc_clr) begin
      pv <= '0;
    end else begin
      pv[0] <= accept;
      for (int i = 1; i < STG; i++) pv[i] <= pv[i-1];
    end
  end

  always_ff @(posedge clk) begin
    pprod[0] <= prod_in;
    pop[0]   <= cmd_op;
    psat[0]  <= cmd_sat;
    for (int i = 1; i < STG; i++) begin
      pprod[i] <= pprod[i-1];
      pop[i]   <= pop[i-1];
      psat[i]  <= psat[i-1];
    end
  end

  logic signed [ACC_W-1:0] sum;
  logic [WORD_W-1:0] nhi, nlo;
  assign sum = $signed({acc_hi, acc_lo}) + pprod[STG-1];

  always_comb begin
    nhi = sum[ACC_W-1:WORD_W];
    nlo = sum[WORD_W-1:0];
    if (psat[STG-1]) begin
      if (!pop[STG-1]) begin
        if (sum[ACC_W-1]) nhi = sum[ACC_W-1:WORD_W] | HI_NEG_SET;
        else              nhi = sum[ACC_W-1:WORD_W] & HI_POS_KEEP;
      end else if (sum < WORD_MIN) begin
        nhi = SAT_MARK;
        nlo = LO_MIN;
      end else if (sum > WORD_MAX) begin
        nhi = SAT_MARK;
        nlo = LO_MAX;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || acc_clr) begin
      acc_hi <= '0;
      acc_lo <= '0;
      done   <= 1'b0;
    end else begin
      done <= fin;
      if (fin) begin
        acc_hi <= nhi;
        acc_lo <= nlo;
      end else if (!busy) begin
        if (wr_hi_en) acc_hi <= wr_hi_data;
        if (wr_lo_en) acc_lo <= wr_lo_data;
      end
    end
  end
endmodule

// File: rtl/mac_sat_unit_chk.sv
`timescale 1ns/1ps
module mac_sat_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic        cmd_op,
  input logic        cmd_sat,
  input logic        acc_clr,
  input logic        wr_hi_en,
  input logic [31:0] wr_hi_data,
  input logic [31:0] acc_hi,
  input logic [31:0] acc_lo,
  input logic        done,
  input logic        busy,
  input logic        fin
);
  logic t_op, t_sat;
  always_ff @(posedge clk) begin
    if (cmd_valid && cmd_ready) begin
      t_op  <= cmd_op;
      t_sat <= cmd_sat;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (acc_hi == 32'h0 && acc_lo == 32'h0 && !done));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  accept_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R9
  idle_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !acc_clr && wr_hi_en) |=> acc_hi == $past(wr_hi_data));

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !fin && !acc_clr) |=> ($stable(acc_hi) && $stable(acc_lo)));

  // R11
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    acc_clr |=> (acc_hi == 32'h0 && acc_lo == 32'h0 && !done));

  // R6
  long_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !t_op && t_sat) |-> (acc_hi[31:16] == 16'hFFFF || acc_hi[31:15] == 17'h0));

  // R7 R8
  word_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (done && t_op && t_sat) |->
      (acc_hi == {32{acc_lo[31]}} ||
       (acc_hi == 32'h1 && (acc_lo == 32'h7FFFFFFF || acc_lo == 32'h80000000))));
endmodule

bind mac_sat_unit mac_sat_unit_chk chk_i (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_sat(cmd_sat), .acc_clr(acc_clr),
  .wr_hi_en(wr_hi_en), .wr_hi_data(wr_hi_data),
  .acc_hi(acc_hi), .acc_lo(acc_lo), .done(done),
  .busy(busy), .fin(fin)
);

// File: tb/mac_sat_unit_tb_top.sv
`timescale 1ns/1ps
module mac_sat_unit_tb_top;
  localparam int STAGES = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 0, cmd_op = 0, cmd_sat = 0, acc_clr = 0;
  logic [31:0] opa = 0, opb = 0;
  logic wr_hi_en = 0, wr_lo_en = 0;
  logic [31:0] wr_hi_data = 0, wr_lo_data = 0;
  logic cmd_ready, done;
  logic [31:0] acc_hi, acc_lo;

  always #10 clk = ~clk;

  mac_sat_unit #(.MUL_STAGES(STAGES)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_sat(cmd_sat), .opa(opa), .opb(opb),
    .acc_clr(acc_clr), .wr_hi_en(wr_hi_en), .wr_hi_data(wr_hi_data),
    .wr_lo_en(wr_lo_en), .wr_lo_data(wr_lo_data),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .done(done));

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit check_en = 0;
  bit finished = 0;

  logic [63:0] m_acc = 0;
  int          m_cnt = 0;
  bit          m_done = 0;
  bit          m_op = 0, m_sat = 0;
  longint      m_prod = 0;

  function automatic logic [63:0] apply_op(logic [63:0] acc, longint prod, bit op, bit sat);
    longint s;
    logic [63:0] r;
    s = longint'(acc) + prod;
    r = s;
    if (sat) begin
      if (!op) begin
        if (s < 0) r[63:32] = r[63:32] | 32'hFFFF0000;
        else       r[63:32] = r[63:32] & 32'h00007FFF;
      end else if (s < -64'sd2147483648) begin
        r = {32'h1, 32'h80000000};
      end else if (s > 64'sd2147483647) begin
        r = {32'h1, 32'h7FFFFFFF};
      end
    end
    return r;
  endfunction

  always @(negedge clk) begin
    bit exp_ready;
    exp_ready = (m_cnt == 0) && !acc_clr;
    if (check_en && !finished) begin
      checks++;
      if ({acc_hi, acc_lo} !== m_acc || done !== m_done || cmd_ready !== exp_ready) begin
        failures++;
        $display("FAIL %s: actual hi=%h lo=%h done=%b ready=%b expected hi=%h lo=%h done=%b ready=%b",
                 cur_req, acc_hi, acc_lo, done, cmd_ready,
                 m_acc[63:32], m_acc[31:0], m_done, exp_ready);
      end
    end
    if (rst || acc_clr) begin
      m_acc = 0; m_cnt = 0; m_done = 0;
      if (rst) check_en = 1;
    end else begin
      m_done = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_acc = apply_op(m_acc, m_prod, m_op, m_sat);
          m_done = 1;
        end
      end else begin
        if (wr_hi_en) m_acc[63:32] = wr_hi_data;
        if (wr_lo_en) m_acc[31:0]  = wr_lo_data;
        if (cmd_valid) begin
          m_op = cmd_op; m_sat = cmd_sat; m_cnt = STAGES;
          if (!cmd_op) m_prod = longint'($signed(opa)) * longint'($signed(opb));
          else         m_prod = longint'($signed(opa[15:0])) * longint'($signed(opb[15:0]));
        end
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic load(bit he, logic [31:0] h, bit le, logic [31:0] l);
    wr_hi_en = he; wr_hi_data = h; wr_lo_en = le; wr_lo_data = l;
    tick();
    wr_hi_en = 0; wr_lo_en = 0;
    tick();
  endtask

  task automatic run(bit op, bit sat, logic [31:0] a, logic [31:0] b);
    cmd_valid = 1; cmd_op = op; cmd_sat = sat; opa = a; opb = b;
    tick();
    cmd_valid = 0;
    tick(STAGES + 1);
  endtask

  task automatic clear();
    acc_clr = 1;
    tick();
    acc_clr = 0;
    tick();
  endtask

  initial begin
    tick(3);
    rst = 0;
    cur_req = "R1"; tick(3);

    cur_req = "R9";
    load(1, 32'h12345678, 1, 32'h9ABCDEF0);
    load(0, 32'h0, 1, 32'h00000042);
    load(1, 32'hCAFEF00D, 0, 32'h0);

    cur_req = "R2";
    clear();
    run(0, 0, 32'd3, 32'd5);
    run(0, 0, 32'hFFFFFFF9, 32'd9);
    run(0, 0, 32'h7FFFFFFF, 32'h7FFFFFFF);
    run(0, 0, 32'h80000000, 32'h80000000);
    load(1, 32'h7FFFFFFF, 1, 32'hFFFFFFFF);
    run(0, 0, 32'd1, 32'd1);

    cur_req = "R3";
    clear();
    run(1, 0, 32'hABCD8000, 32'h1234FFFF);
    run(1, 0, 32'h00007FFF, 32'hFFFF7FFF);
    run(1, 0, 32'h55558000, 32'h00007FFF);
    load(1, 32'hFFFFFFFF, 1, 32'hFFFFFFFF);
    run(1, 0, 32'h0, 32'h1);

    cur_req = "R4";
    run(0, 0, 32'd100, 32'd7);

    cur_req = "R5";
    cmd_valid = 1; cmd_op = 0; cmd_sat = 0; opa = 32'd2; opb = 32'd11;
    tick(4 * (STAGES + 1) + 1);
    cmd_valid = 0;
    tick(STAGES + 2);

    cur_req = "R6";
    clear();
    run(0, 1, 32'h40000000, 32'h40000000);
    run(0, 1, 32'h00001000, 32'h00000010);
    clear();
    run(0, 1, 32'hC0000000, 32'h40000000);
    load(1, 32'h00000000, 1, 32'h00000005);
    run(0, 1, 32'hFFFFFFFF, 32'd9);

    cur_req = "R7";
    load(1, 32'h0, 1, 32'h7FFFFFF0);
    run(1, 1, 32'h00000100, 32'h00000100);
    run(1, 1, 32'h00000001, 32'h00000001);
    load(1, 32'hFFFFFFFF, 1, 32'h80000005);
    run(1, 1, 32'h0000FF00, 32'h00000100);

    cur_req = "R8";
    load(1, 32'h0, 1, 32'h5);
    run(1, 1, 32'h3, 32'h4);
    load(1, 32'hFFFFFFFF, 1, 32'h80000000);
    run(1, 1, 32'h0, 32'h0);
    run(1, 1, 32'h7, 32'h0001);

    cur_req = "R10";
    load(1, 32'h0, 1, 32'h10);
    cmd_valid = 1; cmd_op = 0; cmd_sat = 0; opa = 32'd4; opb = 32'd4;
    tick();
    cmd_valid = 0;
    wr_hi_en = 1; wr_hi_data = 32'hDEADBEEF; wr_lo_en = 1; wr_lo_data = 32'h0BADF00D;
    tick(STAGES);
    wr_hi_en = 0; wr_lo_en = 0;
    tick(2);

    cur_req = "R11";
    load(1, 32'h1111, 1, 32'h2222);
    acc_clr = 1; cmd_valid = 1; cmd_op = 0; opa = 32'd5; opb = 32'd5;
    tick();
    acc_clr = 0; cmd_valid = 0;
    tick(STAGES + 2);
    load(1, 32'h3333, 1, 32'h4444);
    cmd_valid = 1; cmd_op = 1; opa = 32'd6; opb = 32'd6;
    tick();
    cmd_valid = 0; acc_clr = 1;
    tick();
    acc_clr = 0;
    tick(STAGES + 2);
    run(0, 0, 32'd8, 32'd8);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #4000000;
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL %s: actual=hung expected=run completes", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule